// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Capture Unit

This block sits beside an 8-bit input port. Every pin passes through a synchroniser, and software can always read all of them. Selected pins also act as edge-triggered interrupt sources. Pin 1 is a non-maskable source that fires on a rising edge. Pins 2, 3 and 4 are maskable sources. Each has its own enable bit and its own polarity bit, and each owns a 16-bit capture register. On every edge that one of these pins accepts, the capture register loads the value of a free-running timer, which is supplied from outside the block.

A small register interface gives software the following: the synchronised pin levels, the pending flags, the enable and polarity registers, a write-one-to-clear acknowledge register and the three capture registers. A single registered interrupt request line reports that work is waiting. Pin 5 is also brought out in synchronised form as the serial data input of a neighbouring shift-register interface. Vector fetch, arbitration between sources and the timer itself belong to other blocks.

Top module: `pin_event_capture`

## Requirements
- R1: Reading address 0 returns the synchronised levels of all 8 port pins in bits 7:0, whatever the enable and polarity settings.
- R2: A rising edge on pin 1 sets pending bit 1 (address 1), with no enable needed. A falling edge on pin 1 sets nothing.
- R3: Pins 2, 3 and 4 set pending bits 2, 3 and 4 only while the matching enable bit (address 2, bit position equal to the pin number) is 1. While that bit is 0, edges on the pin are ignored.
- R4: Polarity register (address 3, bit position equal to the pin number): 1 selects rising-edge triggering for pins 2 to 4, and 0 selects falling-edge triggering. Edges on pins 0, 5, 6 and 7 never set a pending bit.
- R5: Writing address 4 clears every pending bit whose written data bit is 1. Pending bits written with 0 are unchanged.
- R6: On each accepted edge of pin 2, 3 or 4, the timer value is loaded into that pin's capture register (addresses 5, 6 and 7 respectively). At all other times the capture register holds its value.
- R7: If an acknowledge of a bit and a new accepted edge on that bit fall in the same clock cycle, the pending bit stays set.
- R8: irq_o is 1 one clock after pending bit 1 is set, or after any of pending bits 2 to 4 is set while its enable bit is 1. Otherwise irq_o is 0.
- R9: ser_din_o follows the synchronised level of pin 5.
- R10: A pin change that reaches the port between two clock edges sets its pending bit on the third rising edge that follows. The capture register takes the timer value present at that edge, and irq_o rises one edge later.
- R11: After synchronous reset, all pending, enable, polarity and capture registers read 0, and irq_o is 0.
- R12: The enable and polarity registers store only bits 2 to 4. Every other bit of these registers reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Asynchronous port pins |
| timer_i | input | 16 | Free-running timer value to capture |
| reg_addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 16 | Registered read data of the address from the previous cycle |
| irq_o | output | 1 | Registered interrupt request |
| ser_din_o | output | 1 | Synchronised pin 5 for the serial interface |

## Verification
The bench builds the block with its defaults: an 8-pin port, a 16-bit timer and a two-stage synchroniser. The pin count makes pins 0, 5, 6 and 7 available as distractor inputs. The fixed two-stage chain lets the bench check the exact edge on which a flag and irq_o rise. The timer width lets each captured value be checked as a full 16-bit word that the bench itself chose.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int ADDR_W    = 3;
  localparam int NMI_BIT   = 1;
  localparam int CAP_BASE  = 2;
  localparam int CAP_COUNT = 3;
  localparam int SER_BIT   = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_PINS = 3'd0,
    A_PEND = 3'd1,
    A_EN   = 3'd2,
    A_POL  = 3'd3,
    A_ACK  = 3'd4,
    A_CAP0 = 3'd5,
    A_CAP1 = 3'd6,
    A_CAP2 = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify #(
  parameter int W    = 8,
  parameter int NCAP = 3,
  parameter int BASE = 2,
  parameter int NMI  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    pin_s,
  input  logic [NCAP-1:0] en,
  input  logic [NCAP-1:0] pol,
  output logic [W-1:0]    pin_prev,
  output logic            nmi_evt,
  output logic [NCAP-1:0] cap_evt
);
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= '0;
    else     pin_prev <= pin_s;
  end

  assign rise    = pin_s & ~pin_prev;
  assign fall    = ~pin_s & pin_prev;
  assign nmi_evt = rise[NMI];

  for (genvar k = 0; k < NCAP; k++) begin : g_src
    assign cap_evt[k] = en[k] & (pol[k] ? rise[BASE+k] : fall[BASE+k]);
  end
endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
  parameter int NCAP = 3,
  parameter int TW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCAP-1:0]          evt,
  input  logic [TW-1:0]            timer,
  output logic [NCAP-1:0][TW-1:0]  cap
);
  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    logic [TW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)         r <= '0;
      else if (evt[k]) r <= timer;
    end
    assign cap[k] = r;
  end
endmodule

// File: rtl/pin_event_capture.sv
module pin_event_capture
  import pec_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins_i,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [TMR_W-1:0]  rd_data,
  output logic              irq_o,
  output logic              ser_din_o
);
  logic [PORT_W-1:0]               pin_s, pin_prev;
  logic                            nmi_evt;
  logic [CAP_COUNT-1:0]            cap_evt;
  logic [CAP_COUNT-1:0]            en_q, pol_q;
  logic [CAP_COUNT-1:0][TMR_W-1:0] cap_q;
  logic [PORT_W-1:0]               pend_q, pend_d, set_vec, clr_vec;
  logic                            irq_q;
  logic [TMR_W-1:0]                rd_q, rd_d;
  reg_addr_e                       addr_e;

  assign addr_e = reg_addr_e'(reg_addr);

  pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins_i), .dout(pin_s)
  );

  edge_qualify #(.W(PORT_W), .NCAP(CAP_COUNT), .BASE(CAP_BASE), .NMI(NMI_BIT)) u_edge (
    .clk(clk), .rst(rst), .pin_s(pin_s), .en(en_q), .pol(pol_q),
    .pin_prev(pin_prev), .nmi_evt(nmi_evt), .cap_evt(cap_evt)
  );

  capture_bank #(.NCAP(CAP_COUNT), .TW(TMR_W)) u_cap (
    .clk(clk), .rst(rst), .evt(cap_evt), .timer(timer_i), .cap(cap_q)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[NMI_BIT] = nmi_evt;
    for (int k = 0; k < CAP_COUNT; k++) set_vec[CAP_BASE+k] = cap_evt[k];
    clr_vec = (wr_en && addr_e == A_ACK) ? wr_data : '0;
    pend_d  = (pend_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    rd_d = '0;
    case (addr_e)
      A_PINS: rd_d = TMR_W'(pin_s);
      A_PEND: rd_d = TMR_W'(pend_q);
      A_EN:   rd_d = TMR_W'(en_q) << CAP_BASE;
      A_POL:  rd_d = TMR_W'(pol_q) << CAP_BASE;
      A_CAP0: rd_d = cap_q[0];
      A_CAP1: rd_d = cap_q[1];
      A_CAP2: rd_d = cap_q[2];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_en && addr_e == A_EN)  en_q  <= wr_data[CAP_BASE +: CAP_COUNT];
      if (wr_en && addr_e == A_POL) pol_q <= wr_data[CAP_BASE +: CAP_COUNT];
      pend_q <= pend_d;
      irq_q  <= pend_q[NMI_BIT] | (|(pend_q[CAP_BASE +: CAP_COUNT] & en_q));
      rd_q   <= rd_d;
    end
  end

  assign rd_data   = rd_q;
  assign irq_o     = irq_q;
  assign ser_din_o = pin_s[SER_BIT];
endmodule

// File: rtl/pec_checker.sv
module pec_checker
  import pec_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int TMR_W  = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic [PORT_W-1:0]               pin_s,
  input logic [PORT_W-1:0]               pin_prev,
  input logic [PORT_W-1:0]               pend_q,
  input logic [CAP_COUNT-1:0]            en_q,
  input logic [CAP_COUNT-1:0]            cap_evt,
  input logic [CAP_COUNT-1:0][TMR_W-1:0] cap_q,
  input logic [TMR_W-1:0]                timer_i,
  input logic                            irq_q,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic                            wr_en,
  input logic [PORT_W-1:0]               wr_data
);
  p_nmi_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_s[NMI_BIT] && !pin_prev[NMI_BIT]) |=> pend_q[NMI_BIT]);

  p_irq_up_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_q[NMI_BIT] || (|(pend_q[CAP_BASE +: CAP_COUNT] & en_q))) |=> irq_q);

  p_irq_down_r8: assert property (@(posedge clk) disable iff (rst)
    !(pend_q[NMI_BIT] || (|(pend_q[CAP_BASE +: CAP_COUNT] & en_q))) |=> !irq_q);

  for (genvar k = 0; k < CAP_COUNT; k++) begin : g_src
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (!en_q[k] && !pend_q[CAP_BASE+k]) |=> !pend_q[CAP_BASE+k]);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_addr == A_ACK && wr_data[CAP_BASE+k] && !cap_evt[k])
      |=> !pend_q[CAP_BASE+k]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      cap_evt[k] |=> pend_q[CAP_BASE+k]);

    p_cap_load_r6: assert property (@(posedge clk) disable iff (rst)
      cap_evt[k] |=> cap_q[k] == $past(timer_i));

    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !cap_evt[k] |=> $stable(cap_q[k]));
  end
endmodule

bind pin_event_capture pec_checker #(.PORT_W(PORT_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .pin_s(pin_s), .pin_prev(pin_prev), .pend_q(pend_q),
  .en_q(en_q), .cap_evt(cap_evt), .cap_q(cap_q), .timer_i(timer_i),
  .irq_q(irq_q), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/pin_event_capture_bench.sv
module pin_event_capture_bench;
  localparam int PW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] pins = '0;
  logic [TW-1:0] timer = '0;
  logic [2:0]    reg_addr = '0;
  logic          wr_en = 1'b0;
  logic [PW-1:0] wr_data = '0;
  logic [TW-1:0] rd_data;
  logic          irq_o, ser_din_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  pin_event_capture u_pin_event_capture (
    .clk(clk), .rst(rst), .pins_i(pins), .timer_i(timer), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o),
    .ser_din_o(ser_din_o)
  );

  // Row: {enable, polarity, pins before, pins after, expected pending}
  localparam logic [39:0] TBL [8] = '{
    {8'h1C, 8'h1C, 8'h00, 8'h1E, 8'h1E},
    {8'h1C, 8'h00, 8'h1E, 8'h00, 8'h1C},
    {8'h00, 8'h1C, 8'h00, 8'h1C, 8'h00},
    {8'h04, 8'h04, 8'h00, 8'h1C, 8'h04},
    {8'h1C, 8'h14, 8'h08, 8'h14, 8'h1C},
    {8'h1C, 8'h1C, 8'h1C, 8'h00, 8'h00},
    {8'h18, 8'h00, 8'hFF, 8'hE1, 8'h18},
    {8'h1C, 8'h1C, 8'h00, 8'hE1, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PW-1:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [TW-1:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq after reset", 32'(irq_o), 32'h0);
    rd(3'd1, v); check("R11 pending after reset", 32'(v), 32'h0);
    rd(3'd2, v); check("R11 enable after reset", 32'(v), 32'h0);
    rd(3'd5, v); check("R11 capture after reset", 32'(v), 32'h0);

    // R12 unused bits read zero
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R12 enable bits", 32'(v), 32'h1C);
    wr(3'd3, 8'hE3); rd(3'd3, v); check("R12 polarity bits", 32'(v), 32'h00);

    // Table walk: R1 R2 R3 R4 R6 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [7:0] en, pol, p0, p1, ex;
      logic [TW-1:0] tv;
      {en, pol, p0, p1, ex} = TBL[i];
      wr(3'd2, en); wr(3'd3, pol);
      @(negedge clk); pins = p0;
      settle(6);
      wr(3'd4, 8'hFF);
      tv = 16'h1000 + 16'(i) * 16'h0111;
      @(negedge clk); timer = tv; pins = p1;
      settle(6);
      rd(3'd1, v); check("R2 R3 R4 pending row", 32'(v), 32'(ex));
      rd(3'd0, v); check("R1 pin read row", 32'(v), 32'(p1));
      check("R8 irq row", 32'(irq_o), 32'(ex != 8'h00));
      check("R9 serial input row", 32'(ser_din_o), 32'(p1[5]));
      for (int k = 0; k < 3; k++) begin
        if (ex[2+k]) begin
          rd(3'(5 + k), v); check("R6 capture row", 32'(v), 32'(tv));
        end
      end
    end

    // R5 partial acknowledge
    wr(3'd2, 8'h1C); wr(3'd3, 8'h1C);
    @(negedge clk); pins = 8'h00; settle(6);
    wr(3'd4, 8'hFF);
    @(negedge clk); pins = 8'h1E; settle(6);
    wr(3'd4, 8'h04); rd(3'd1, v); check("R5 clear bit 2 only", 32'(v), 32'h1A);
    wr(3'd4, 8'h00); rd(3'd1, v); check("R5 zero write no effect", 32'(v), 32'h1A);
    wr(3'd4, 8'h02); rd(3'd1, v); check("R5 clear nmi bit", 32'(v), 32'h18);

    // R10 latency: falling edge on pin 3
    wr(3'd3, 8'h00); settle(3); wr(3'd4, 8'hFF); settle(2);
    @(negedge clk); timer = 16'hBEEF; pins = 8'h16;
    @(negedge clk); check("R10 irq low after edge 1", 32'(irq_o), 32'h0);
    @(negedge clk); check("R10 irq low after edge 2", 32'(irq_o), 32'h0);
    @(negedge clk); check("R10 irq low after edge 3", 32'(irq_o), 32'h0);
    @(negedge clk); check("R10 irq high after edge 4", 32'(irq_o), 32'h1);
    timer = 16'h0000;
    rd(3'd6, v); check("R10 captured timer at flag edge", 32'(v), 32'hBEEF);

    // R6 hold and R3 ignore while disabled
    wr(3'd4, 8'hFF); wr(3'd2, 8'h00);
    @(negedge clk); timer = 16'h1234; pins = 8'h1E; settle(6);
    @(negedge clk); pins = 8'h16; settle(6);
    rd(3'd6, v); check("R6 capture holds when disabled", 32'(v), 32'hBEEF);
    rd(3'd1, v); check("R3 disabled pin sets nothing", 32'(v & 16'h1C), 32'h0);

    // R7 acknowledge in the same cycle as a new edge
    wr(3'd2, 8'h1C); wr(3'd3, 8'h1C);
    @(negedge clk); pins = 8'h1E; settle(6);
    @(negedge clk); pins = 8'h16; settle(6);
    @(negedge clk); pins = 8'h1E;
    @(negedge clk);
    @(negedge clk); reg_addr = 3'd4; wr_data = 8'h08; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd1, v); check("R7 set wins over ack", 32'(v[3]), 32'h1);
    wr(3'd4, 8'h08); rd(3'd1, v); check("R7 plain ack clears", 32'(v[3]), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule